// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block is the hazard control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) whose datapath already forwards results from later stages. From the register fields and control bits held in the decode, execute and memory pipeline registers, it decides each cycle whether the front end advances normally, holds while a bubble goes down the pipe, or throws away a wrongly fetched instruction after a taken branch. All outputs are purely combinational functions of the stage fields. The datapath applies them at the next clock edge.

Two situations force a hold. The first is a value loaded from memory that the next instruction needs in execute. The second is a branch resolved in decode whose comparison operands are still being produced. During a hold, the program counter and the decode register keep their contents and the control bits entering execute are cleared. Branches are assumed not taken. When decode resolves a branch as taken, the fetched instruction is discarded and the program counter is loaded with the branch target. This costs one cycle. A not-taken branch costs nothing.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When execute holds a load whose destination is nonzero and equal to either source of the decode instruction, outputs are pc_we=0, ifid_we=0, idex_zero=1, ifid_flush=0, pc_take_target=0.
- R2: Register index 0 never causes a hold, as a load destination in execute or in memory.
- R3: A non-load writer in execute whose destination matches a source of a non-branch decode instruction causes no hold, because forwarding covers it.
- R4: A branch in decode holds when either of its sources equals a nonzero destination being written by the instruction in execute, whether a load or not.
- R5: A branch in decode holds when either of its sources equals the nonzero destination of a load in memory. A non-load in memory does not hold it.
- R6: A not-taken branch with no hazard produces the pass encoding (pc_we=1, ifid_we=1, all else 0) and adds no cycles.
- R7: A taken branch with no hazard gives pc_take_target=1, ifid_flush=1, pc_we=1, ifid_we=1, idex_zero=0, and adds exactly one cycle. The wrong-path instruction never reaches execute.
- R8: br_taken has no effect unless decode holds a branch whose operands are ready.
- R9: Flush takes priority over a hold. ifid_flush and idex_zero are never both 1.
- R10: With no hazard and no branch, the pass encoding is produced, so one instruction enters execute per cycle.
- R11: A load-use pair costs exactly one extra cycle. A load feeding a taken branch in the next instruction costs two hold cycles plus the redirect cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs1 | input | 5 | First source register of the decode-stage instruction |
| dec_rs2 | input | 5 | Second source register of the decode-stage instruction |
| dec_is_branch | input | 1 | Decode instruction is a conditional branch |
| dec_br_taken | input | 1 | Branch outcome computed in decode (1 = taken) |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_rd | input | 5 | Destination register of the execute-stage instruction |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| pc_we | output | 1 | Program counter may be written this cycle |
| ifid_we | output | 1 | Decode pipeline register may load |
| ifid_flush | output | 1 | Decode pipeline register is cleared to a no-op |
| idex_zero | output | 1 | Control bits written into the execute register are forced to 0 |
| pc_take_target | output | 1 | Program counter loads the branch target |

## Verification
The assertions assume that the stage fields describe a pipeline that is consistent with itself. In particular, they assume dec_br_taken reflects a real comparison only when the branch operands are ready, and that a load always carries its destination. The bench feeds the block from a behavioural pipeline model that moves instructions only as the block's outputs allow, so every input combination it produces is one a real pipeline could reach. A separate vector table reaches the priority and register-zero corners directly, and each of those vectors is still a legal stage snapshot.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int unsigned RA_W = 5;
    localparam int unsigned NSRC = 2;

    typedef logic [RA_W-1:0] ra_t;

    // producer held in a later pipeline register
    typedef struct packed {
        logic wen;
        logic is_load;
        ra_t  rd;
    } prod_t;

    // front-end control bundle
    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic ifid_flush;
        logic idex_zero;
        logic pc_take_target;
    } ctl_t;

    localparam ctl_t CTL_PASS = '{pc_we: 1'b1, ifid_we: 1'b1, ifid_flush: 1'b0,
                                  idex_zero: 1'b0, pc_take_target: 1'b0};

    function automatic logic live_dst(prod_t p);
        return p.wen && (p.rd != '0);
    endfunction

endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
    parameter int unsigned N = 2,
    parameter int unsigned W = 5
) (
    input  logic [N-1:0][W-1:0] srcs,
    input  logic [W-1:0]        rd,
    input  logic                en,
    output logic                hit
);
    logic [N-1:0] eq;

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign eq[g] = (srcs[g] == rd);
        end
    endgenerate

    assign hit = en && (rd != '0) && (|eq);
endmodule

// File: rtl/hzd_detect.sv
module hzd_detect
    import hzd_pkg::*;
(
    input  ra_t [NSRC-1:0] srcs,
    input  logic           is_branch,
    input  prod_t          ex_p,
    input  prod_t          mem_p,
    output logic           load_use,
    output logic           br_wait
);
    logic ex_hit;
    logic mem_hit;

    hzd_match #(.N(NSRC), .W(RA_W)) u_ex_cmp (
        .srcs (srcs),
        .rd   (ex_p.rd),
        .en   (ex_p.wen),
        .hit  (ex_hit)
    );

    hzd_match #(.N(NSRC), .W(RA_W)) u_mem_cmp (
        .srcs (srcs),
        .rd   (mem_p.rd),
        .en   (mem_p.wen && mem_p.is_load),
        .hit  (mem_hit)
    );

    assign load_use = ex_hit && ex_p.is_load;
    assign br_wait  = is_branch && (ex_hit || mem_hit);

    always_comb begin
        if (is_branch && live_dst(ex_p) && (ex_p.rd == srcs[0]))
            a_r4_branch_waits_on_ex: assert (br_wait);
        if (!is_branch && !ex_p.is_load)
            a_r3_forward_no_hold: assert (!load_use && !br_wait);
    end
endmodule

// File: rtl/hzd_arbiter.sv
module hzd_arbiter
    import hzd_pkg::*;
(
    input  logic load_use,
    input  logic br_wait,
    input  logic is_branch,
    input  logic taken,
    output ctl_t ctl
);
    logic redirect;
    logic hold;

    assign redirect = is_branch && taken && !br_wait;
    assign hold     = load_use || br_wait;

    always_comb begin
        ctl = CTL_PASS;
        if (redirect) begin
            ctl.ifid_flush     = 1'b1;
            ctl.pc_take_target = 1'b1;
        end else if (hold) begin
            ctl.pc_we     = 1'b0;
            ctl.ifid_we   = 1'b0;
            ctl.idex_zero = 1'b1;
        end
    end

    always_comb begin
        a_r9_flush_excl: assert (!(ctl.ifid_flush && ctl.idex_zero));
        if (ctl.pc_take_target)
            a_r7_redirect_writes_pc: assert (ctl.pc_we && ctl.ifid_we);
    end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import hzd_pkg::*;
(
    input  logic [4:0] dec_rs1,
    input  logic [4:0] dec_rs2,
    input  logic       dec_is_branch,
    input  logic       dec_br_taken,
    input  logic       ex_wen,
    input  logic       ex_is_load,
    input  logic [4:0] ex_rd,
    input  logic       mem_is_load,
    input  logic [4:0] mem_rd,
    output logic       pc_we,
    output logic       ifid_we,
    output logic       ifid_flush,
    output logic       idex_zero,
    output logic       pc_take_target
);
    ra_t [NSRC-1:0] srcs;
    prod_t ex_p;
    prod_t mem_p;
    logic  load_use;
    logic  br_wait;
    ctl_t  ctl;

    assign srcs[0] = dec_rs1;
    assign srcs[1] = dec_rs2;

    assign ex_p  = '{wen: ex_wen || ex_is_load, is_load: ex_is_load, rd: ex_rd};
    assign mem_p = '{wen: mem_is_load, is_load: mem_is_load, rd: mem_rd};

    hzd_detect u_detect (
        .srcs      (srcs),
        .is_branch (dec_is_branch),
        .ex_p      (ex_p),
        .mem_p     (mem_p),
        .load_use  (load_use),
        .br_wait   (br_wait)
    );

    hzd_arbiter u_arb (
        .load_use  (load_use),
        .br_wait   (br_wait),
        .is_branch (dec_is_branch),
        .taken     (dec_br_taken),
        .ctl       (ctl)
    );

    assign pc_we          = ctl.pc_we;
    assign ifid_we        = ctl.ifid_we;
    assign ifid_flush     = ctl.ifid_flush;
    assign idex_zero      = ctl.idex_zero;
    assign pc_take_target = ctl.pc_take_target;

    always_comb begin
        if (ex_is_load && ex_rd != '0 && (ex_rd == dec_rs1 || ex_rd == dec_rs2))
            a_r1_load_use_holds: assert (!pc_we && !ifid_we && idex_zero && !ifid_flush);
        if (ex_rd == '0 && (!mem_is_load || mem_rd == '0))
            a_r2_zero_reg_no_hold: assert (pc_we && !idex_zero);
        if (!dec_is_branch)
            a_r8_taken_ignored: assert (!ifid_flush && !pc_take_target);
    end
endmodule

// File: tb/tb_pipe_hazard_ctl.sv
module tb_pipe_hazard_ctl;

    typedef struct packed {
        logic [4:0] rs1, rs2;
        logic       br, tk, exw, exl;
        logic [4:0] exrd;
        logic       meml;
        logic [4:0] memrd;
        logic [4:0] exp;   // {pc_we, ifid_we, flush, zero, target}
    } vec_t;

    localparam logic [4:0] PASS  = 5'b11000;
    localparam logic [4:0] HOLD  = 5'b00010;
    localparam logic [4:0] REDIR = 5'b11101;
    localparam int NV = 13;

    localparam vec_t VECS [NV] = '{
        '{5'd1, 5'd2, 1'b0, 1'b0, 1'b1, 1'b0, 5'd3, 1'b0, 5'd0, PASS },  // R10
        '{5'd5, 5'd1, 1'b0, 1'b0, 1'b1, 1'b1, 5'd5, 1'b0, 5'd0, HOLD },  // R1 rs1
        '{5'd1, 5'd5, 1'b0, 1'b0, 1'b1, 1'b1, 5'd5, 1'b0, 5'd0, HOLD },  // R1 rs2
        '{5'd0, 5'd2, 1'b0, 1'b0, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, PASS },  // R2
        '{5'd6, 5'd2, 1'b0, 1'b0, 1'b1, 1'b0, 5'd6, 1'b0, 5'd0, PASS },  // R3
        '{5'd6, 5'd2, 1'b1, 1'b1, 1'b1, 1'b0, 5'd6, 1'b0, 5'd0, HOLD },  // R4
        '{5'd3, 5'd9, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 5'd9, HOLD },  // R5
        '{5'd0, 5'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 5'd0, PASS },  // R2
        '{5'd3, 5'd2, 1'b1, 1'b0, 1'b1, 1'b0, 5'd8, 1'b0, 5'd0, PASS },  // R6
        '{5'd3, 5'd2, 1'b1, 1'b1, 1'b1, 1'b0, 5'd8, 1'b0, 5'd0, REDIR},  // R7
        '{5'd3, 5'd2, 1'b0, 1'b1, 1'b1, 1'b0, 5'd8, 1'b0, 5'd0, PASS },  // R8
        '{5'd4, 5'd2, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 5'd4, REDIR},  // R5 ALU in mem
        '{5'd7, 5'd2, 1'b0, 1'b1, 1'b1, 1'b1, 5'd7, 1'b0, 5'd0, HOLD }   // R9
    };

    typedef struct packed {
        logic       vld, ld, br, tk, wen;
        logic [4:0] rd, rs1, rs2;
        logic [3:0] tgt;
        logic [3:0] tag;
    } ins_t;

    localparam ins_t NOP = '0;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [4:0] dec_rs1, dec_rs2, ex_rd, mem_rd;
    logic dec_is_branch, dec_br_taken, ex_wen, ex_is_load, mem_is_load;
    logic pc_we, ifid_we, ifid_flush, idex_zero, pc_take_target;

    int n_chk = 0;
    int n_bad = 0;
    bit vec_mode = 1'b0;
    vec_t cur;
    ins_t ifid = NOP, idex = NOP, exmem = NOP;
    ins_t prog [16];
    int pc = 0;

    assign dec_rs1       = vec_mode ? cur.rs1   : ifid.rs1;
    assign dec_rs2       = vec_mode ? cur.rs2   : ifid.rs2;
    assign dec_is_branch = vec_mode ? cur.br    : (ifid.vld && ifid.br);
    assign dec_br_taken  = vec_mode ? cur.tk    : ifid.tk;
    assign ex_wen        = vec_mode ? cur.exw   : (idex.vld && idex.wen);
    assign ex_is_load    = vec_mode ? cur.exl   : (idex.vld && idex.ld);
    assign ex_rd         = vec_mode ? cur.exrd  : idex.rd;
    assign mem_is_load   = vec_mode ? cur.meml  : (exmem.vld && exmem.ld);
    assign mem_rd        = vec_mode ? cur.memrd : exmem.rd;

    pipe_hazard_ctl dut (
        .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_is_branch(dec_is_branch),
        .dec_br_taken(dec_br_taken), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
        .ex_rd(ex_rd), .mem_is_load(mem_is_load), .mem_rd(mem_rd),
        .pc_we(pc_we), .ifid_we(ifid_we), .ifid_flush(ifid_flush),
        .idex_zero(idex_zero), .pc_take_target(pc_take_target)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic ins_t mk(input logic ld, input logic br, input logic tk,
                                input logic [4:0] rd, input logic [4:0] rs1,
                                input logic [4:0] rs2, input logic [3:0] tgt,
                                input logic [3:0] tag);
        ins_t t;
        t.vld = 1'b1; t.ld = ld; t.br = br; t.tk = tk;
        t.wen = !br && (rd != 5'd0);
        t.rd = br ? 5'd0 : rd; t.rs1 = rs1; t.rs2 = rs2; t.tgt = tgt; t.tag = tag;
        return t;
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) prog[i] = NOP;
    endtask

    // steps until the tag-15 instruction enters execute; tag 14 marks wrong path
    task automatic run_prog(output int steps, output bit poisoned);
        ins_t nif;
        int npc;
        ifid = NOP; idex = NOP; exmem = NOP; pc = 0;
        steps = 0; poisoned = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            npc = pc_take_target ? int'(ifid.tgt) : (pc_we ? pc + 1 : pc);
            if (ifid_flush)   nif = NOP;
            else if (ifid_we) nif = (pc < 16) ? prog[pc] : NOP;
            else              nif = ifid;
            exmem = idex;
            idex  = idex_zero ? NOP : ifid;
            ifid  = nif;
            pc    = npc;
            steps++;
            if (idex.vld && idex.tag == 4'd14) poisoned = 1'b1;
            if (idex.vld && idex.tag == 4'd15) break;
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20ns * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int st;
        bit po;
        // empty pipeline state (R10)
        @(negedge clk);
        check("R10 empty pipe", {pc_we, ifid_we, ifid_flush, idex_zero, pc_take_target}, PASS);

        vec_mode = 1'b1;
        for (int i = 0; i < NV; i++) begin
            cur = VECS[i];
            #1;
            check($sformatf("vector %0d (R1..R10 table)", i),
                  {pc_we, ifid_we, ifid_flush, idex_zero, pc_take_target}, cur.exp);
        end
        vec_mode = 1'b0;

        // R10 straight line
        clear_prog();
        prog[0] = mk(0,0,0,5'd1,5'd2,5'd3,0,0);
        prog[1] = mk(0,0,0,5'd4,5'd5,5'd6,0,1);
        prog[2] = mk(0,0,0,5'd7,5'd8,5'd9,0,2);
        prog[3] = mk(0,0,0,5'd10,5'd11,5'd12,0,15);
        run_prog(st, po); check("R10 straight-line steps", st, 5);

        // R1 R11 load-use
        clear_prog();
        prog[0] = mk(1,0,0,5'd5,5'd2,5'd3,0,0);
        prog[1] = mk(0,0,0,5'd6,5'd5,5'd1,0,1);
        prog[2] = mk(0,0,0,5'd7,5'd8,5'd9,0,15);
        run_prog(st, po); check("R11 load-use steps", st, 5);

        // R2 load to register zero
        clear_prog();
        prog[0] = mk(1,0,0,5'd0,5'd2,5'd3,0,0);
        prog[1] = mk(0,0,0,5'd6,5'd0,5'd1,0,1);
        prog[2] = mk(0,0,0,5'd7,5'd8,5'd9,0,15);
        run_prog(st, po); check("R2 zero-reg steps", st, 4);

        // R6 not taken
        clear_prog();
        prog[0] = mk(0,1,0,5'd0,5'd2,5'd3,4'd3,0);
        prog[1] = mk(0,0,0,5'd6,5'd1,5'd1,0,1);
        prog[2] = mk(0,0,0,5'd7,5'd8,5'd9,0,15);
        run_prog(st, po); check("R6 not-taken steps", st, 4);
        check("R6 fall-through executed", po, 0);

        // R7 taken
        clear_prog();
        prog[0] = mk(0,1,1,5'd0,5'd2,5'd3,4'd3,0);
        prog[1] = mk(0,0,0,5'd6,5'd1,5'd1,0,14);
        prog[2] = mk(0,0,0,5'd6,5'd1,5'd1,0,14);
        prog[3] = mk(0,0,0,5'd7,5'd8,5'd9,0,15);
        run_prog(st, po); check("R7 taken steps", st, 4);
        check("R7 wrong path flushed", po, 0);

        // R4 ALU result feeding branch
        clear_prog();
        prog[0] = mk(0,0,0,5'd7,5'd2,5'd3,0,0);
        prog[1] = mk(0,1,1,5'd0,5'd7,5'd1,4'd4,1);
        prog[2] = mk(0,0,0,5'd6,5'd1,5'd1,0,14);
        prog[4] = mk(0,0,0,5'd9,5'd8,5'd9,0,15);
        run_prog(st, po); check("R4 alu-to-branch steps", st, 6);
        check("R4 wrong path flushed", po, 0);

        // R5 R11 load feeding branch
        clear_prog();
        prog[0] = mk(1,0,0,5'd4,5'd2,5'd3,0,0);
        prog[1] = mk(0,1,1,5'd0,5'd1,5'd4,4'd4,1);
        prog[2] = mk(0,0,0,5'd6,5'd1,5'd1,0,14);
        prog[4] = mk(0,0,0,5'd9,5'd8,5'd9,0,15);
        run_prog(st, po); check("R5 load-to-branch steps", st, 7);
        check("R5 wrong path flushed", po, 0);

        finish_run();
    end
endmodule